// File: doc/BRIEF.md
# Single-Precision to 16-Bit Float Narrowing Converter

This block takes one IEEE 754 single-precision operand and produces a 16-bit floating-point result. The result is either IEEE half precision (5-bit exponent, 10-bit fraction) or bfloat16 (8-bit exponent, 7-bit fraction), chosen per operand by a format-select bit. A two-bit field chooses one of four rounding modes for each operand. Denormal operands are read as signed zero. The block never emits a subnormal result. NaNs keep their sign and upper payload and always leave quiet. Infinities pass through unchanged. Results too large for the target format either saturate or become infinity, depending on the rounding mode.

Each result carries two status bits: overflow and inexact. Operands enter through a valid/ready handshake. Each accepted operand yields exactly one registered result one clock later. A consumer that holds its ready signal low stalls the unit.

Top module: `f32_narrow_cvt`

## Requirements
- R1: `in_fmt`=0 selects half precision (exponent bias 15) and `in_fmt`=1 selects bfloat16 (exponent bias 127). A normal operand whose value fits exactly is rebiased, and its fraction keeps its upper bits.
- R2: `in_rnd` encodes 0 = round to nearest, ties to even; 1 = toward zero; 2 = toward +infinity; 3 = toward -infinity. The rounding decision comes from the guard bit, the round bit and the sticky bit of the discarded fraction. A carry out of the fraction increments the exponent.
- R3: A finite operand whose rounded exponent exceeds the largest finite exponent sets both `out_flags[1]` (overflow) and `out_flags[0]` (inexact). The result is then infinity for mode 0. For mode 1 it is the largest finite value. For mode 2 it is +infinity or the most negative finite value. For mode 3 it is -infinity or the most positive finite value.
- R4: A denormal operand (exponent 0, fraction nonzero) gives a zero with the operand's sign and sets only inexact. A true zero gives a signed zero with no flags.
- R5: An operand whose exponent lies below the target's normal range is flushed to a signed zero and sets inexact. No output is ever subnormal.
- R6: A quiet NaN operand gives a NaN with the same sign. The output's all-ones exponent carries the top fraction bits that fit, and no flags are raised.
- R7: A signaling NaN operand gives a quiet NaN. The output fraction takes the operand's top fraction bits with its MSB forced to 1, the sign is kept and no flags are raised.
- R8: An infinite operand gives an infinity of the same sign with no flags.
- R9: Inexact is set exactly when discarded fraction bits are nonzero or a flush to zero happens. Exact conversions raise no flags.
- R10: `in_ready` is high when the output register is empty or is being drained. An accepted operand's result appears with `out_valid` on the next cycle, and it stays stable while `out_ready` is low.
- R11: While `rst` is high, and in the cycle after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can accept an operand this cycle |
| in_op | input | 32 | Single-precision operand |
| in_fmt | input | 1 | Target format: 0 half, 1 bfloat16 |
| in_rnd | input | 2 | Rounding mode (see R2) |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 16 | Converted value |
| out_flags | output | 2 | [1] overflow, [0] inexact |

## Verification
The hardest cases to reach are those where rounding alone changes the result's class. Examples are a tie that carries out of the fraction into the next binade, and a value just above the largest half-precision finite that only overflows after the increment. The stimulus reaches these with hand-built bit patterns at exact guard/sticky boundaries (65504 versus 65520, an all-ones fraction, paired tie cases with even and odd LSBs), each run under several rounding modes and both signs. Backpressure is exercised by forcing the consumer's ready low while a result is pending, then driving it randomly for the rest of the run.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam int SRC_EW   = 8;
    localparam int SRC_MW   = 23;
    localparam int SRC_BIAS = 127;
    localparam int DST_W    = 16;

    typedef enum logic {
        FMT_HALF = 1'b0,
        FMT_BF16 = 1'b1
    } fmt_e;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_ZERO      = 2'd1,
        RM_UP        = 2'd2,
        RM_DOWN      = 2'd3
    } rnd_e;

    typedef enum logic [1:0] {
        CL_ZERO,
        CL_NORM,
        CL_INF,
        CL_NAN
    } cls_e;

    typedef struct packed {
        logic              sign;
        logic [SRC_EW-1:0] exp;
        logic [SRC_MW-1:0] man;
        cls_e              cls;
        logic              denorm;
    } src_t;

    typedef struct packed {
        logic [DST_W-1:0] bits;
        logic             ovf;
        logic             nx;
    } res_t;

    // Increment decision for the kept fraction.
    function automatic logic round_up(rnd_e rm, logic sign, logic lsb,
                                      logic g, logic r, logic st);
        logic any;
        any = g | r | st;
        unique case (rm)
            RM_NEAR_EVEN: return g & (r | st | lsb);
            RM_ZERO:      return 1'b0;
            RM_UP:        return ~sign & any;
            RM_DOWN:      return sign & any;
            default:      return 1'b0;
        endcase
    endfunction

    // On overflow: does the mode choose infinity (1) or largest finite (0)?
    function automatic logic ovf_to_inf(rnd_e rm, logic sign);
        unique case (rm)
            RM_NEAR_EVEN: return 1'b1;
            RM_ZERO:      return 1'b0;
            RM_UP:        return ~sign;
            RM_DOWN:      return sign;
            default:      return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/f32_classify.sv
module f32_classify
    import fcvt_pkg::*;
(
    input  logic [31:0] op,
    output src_t        src
);
    logic [SRC_EW-1:0] e;
    logic [SRC_MW-1:0] m;

    assign e = op[30:23];
    assign m = op[22:0];

    always_comb begin
        src.sign   = op[31];
        src.exp    = e;
        src.man    = m;
        src.denorm = 1'b0;
        if (e == '0) begin
            src.cls    = CL_ZERO;
            src.denorm = (m != '0);
        end else if (e == '1) begin
            src.cls = (m == '0) ? CL_INF : CL_NAN;
        end else begin
            src.cls = CL_NORM;
        end
    end
endmodule

// File: rtl/fp_narrow_core.sv
module fp_narrow_core
    import fcvt_pkg::*;
#(
    parameter int EW = 5,
    parameter int MW = 10
) (
    input  src_t src,
    input  rnd_e rm,
    output res_t res
);
    localparam int DROP = SRC_MW - MW;
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int EMAX = (1 << EW) - 2;
    localparam logic [EW-1:0] EMAX_V = EW'(EMAX);
    localparam logic [EW-1:0] EXP_ONES = '1;

    logic [MW-1:0] kept;
    logic [MW-1:0] pay;
    logic [MW:0]   sum;
    logic          g, r, st, inc, lost;
    int            eo_pre, eo_post;

    always_comb begin
        kept    = src.man[SRC_MW-1 -: MW];
        g       = src.man[DROP-1];
        r       = src.man[DROP-2];
        st      = |src.man[DROP-3:0];
        lost    = g | r | st;
        inc     = round_up(rm, src.sign, kept[0], g, r, st);
        sum     = {1'b0, kept} + {{MW{1'b0}}, inc};
        eo_pre  = int'(src.exp) - SRC_BIAS + BIAS;
        eo_post = eo_pre + int'(sum[MW]);
        pay     = kept;
        pay[MW-1] = 1'b1;

        res.bits = {src.sign, {(DST_W-1){1'b0}}};
        res.ovf  = 1'b0;
        res.nx   = 1'b0;

        unique case (src.cls)
            CL_ZERO: res.nx = src.denorm;
            CL_INF:  res.bits = {src.sign, EXP_ONES, {MW{1'b0}}};
            CL_NAN:  res.bits = {src.sign, EXP_ONES, pay};
            default: begin
                if (eo_pre < 1) begin
                    res.nx = 1'b1;
                end else if (eo_post > EMAX) begin
                    res.ovf  = 1'b1;
                    res.nx   = 1'b1;
                    res.bits = ovf_to_inf(rm, src.sign)
                             ? {src.sign, EXP_ONES, {MW{1'b0}}}
                             : {src.sign, EMAX_V, {MW{1'b1}}};
                end else begin
                    res.bits = {src.sign, eo_post[EW-1:0], sum[MW-1:0]};
                    res.nx   = lost;
                end
            end
        endcase
    end
endmodule

// File: rtl/cvt_out_reg.sv
module cvt_out_reg
    import fcvt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  res_t d,
    input  logic drain,
    output logic valid,
    output res_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else if (load) begin
            valid <= 1'b1;
            q     <= d;
        end else if (drain) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/f32_narrow_cvt.sv
module f32_narrow_cvt
    import fcvt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_op,
    input  logic        in_fmt,
    input  logic [1:0]  in_rnd,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [15:0] out_res,
    output logic [1:0]  out_flags
);
    localparam int NFMT = 2;

    src_t src;
    res_t per_fmt [NFMT];
    res_t sel, held;
    logic fire;
    rnd_e rm;

    assign rm = rnd_e'(in_rnd);

    f32_classify u_cls (.op(in_op), .src(src));

    for (genvar i = 0; i < NFMT; i++) begin : g_fmt
        localparam int EW = (i == int'(FMT_BF16)) ? 8 : 5;
        fp_narrow_core #(.EW(EW), .MW(DST_W - 1 - EW)) u_core (
            .src(src), .rm(rm), .res(per_fmt[i])
        );
    end

    assign sel      = per_fmt[in_fmt];
    assign in_ready = ~out_valid | out_ready;
    assign fire     = in_valid & in_ready;

    cvt_out_reg u_oreg (
        .clk(clk), .rst(rst), .load(fire), .d(sel),
        .drain(out_ready), .valid(out_valid), .q(held)
    );

    assign out_res   = held.bits;
    assign out_flags = {held.ovf, held.nx};
endmodule

// File: rtl/f32_narrow_cvt_chk.sv
module f32_narrow_cvt_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_op,
    input logic        in_fmt,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_res,
    input logic [1:0]  out_flags
);
    logic fire, fmt_q, rst_d, op_inf, op_nan;
    assign fire   = in_valid & in_ready;
    assign op_inf = (in_op[30:23] == 8'hff) && (in_op[22:0] == '0);
    assign op_nan = (in_op[30:23] == 8'hff) && (in_op[22:0] != '0);

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) fmt_q <= 1'b0;
        else if (fire) fmt_q <= in_fmt;
    end

    always @(posedge clk) begin
        if (rst_d) a_reset_r11: assert (!out_valid);
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_flags));
    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);
    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        fire |=> out_valid);
    p_ovf_nx_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_flags[1] |-> out_flags[0]);
    p_no_sub_half_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && !fmt_q |-> !(out_res[14:10] == '0 && out_res[9:0] != '0));
    p_no_sub_bf_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && fmt_q |-> !(out_res[14:7] == '0 && out_res[6:0] != '0));
    p_inf_r8: assert property (@(posedge clk) disable iff (rst)
        fire && op_inf |=> out_flags == 2'b00);
    p_nan_half_r7: assert property (@(posedge clk) disable iff (rst)
        fire && op_nan && !in_fmt |=> out_res[14:10] == 5'h1f && out_res[9] && out_flags == 2'b00);
    p_nan_bf_r6: assert property (@(posedge clk) disable iff (rst)
        fire && op_nan && in_fmt |=> out_res[14:7] == 8'hff && out_res[6] && out_flags == 2'b00);
endmodule

bind f32_narrow_cvt f32_narrow_cvt_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_fmt(in_fmt), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_flags(out_flags)
);

// File: tb/sim_f32_narrow_cvt.sv
module sim_f32_narrow_cvt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_op = '0;
    logic        in_fmt = 1'b0;
    logic [1:0]  in_rnd = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_res;
    logic [1:0]  out_flags;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    logic rdy_force = 1'b1;
    logic rdy_val = 1'b0;

    logic [17:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    f32_narrow_cvt u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_fmt(in_fmt), .in_rnd(in_rnd),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_res(out_res), .out_flags(out_flags)
    );

    always @(posedge clk) begin
        #1 out_ready <= rdy_force ? rdy_val : (($urandom % 4) != 0);
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Scoreboard monitor: a transfer happens at the next posedge.
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R10 unexpected output", {14'd0, out_flags, out_res}, 32'd0);
            end else begin
                logic [17:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_flags, out_res} == e, t, {14'd0, out_flags, out_res}, {14'd0, e});
            end
        end
    end

    task automatic send(logic [31:0] op, logic fmt, logic [1:0] rnd,
                        logic [15:0] res, logic [1:0] flg, string tag);
        in_op = op; in_fmt = fmt; in_rnd = rnd; in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        exp_q.push_back({flg, res});
        tag_q.push_back(tag);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R11 reset out_valid", {31'd0, out_valid}, 32'd0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R11 after reset", {31'd0, out_valid}, 32'd0);

        // Backpressure: result held while consumer stalls.
        @(posedge clk); #1;
        send(32'h3F800000, 1'b0, 2'd0, 16'h3C00, 2'b00, "R1 half 1.0");
        @(negedge clk);
        check(out_valid == 1'b1, "R10 latency", {31'd0, out_valid}, 32'd1);
        check(in_ready == 1'b0, "R10 stall ready", {31'd0, in_ready}, 32'd0);
        repeat (3) begin
            @(negedge clk);
            check(out_res == 16'h3C00, "R10 held", {16'd0, out_res}, 32'h3C00);
        end
        rdy_force = 1'b0;

        // R1 formats
        send(32'h3F800000, 1'b1, 2'd0, 16'h3F80, 2'b00, "R1 bf16 1.0");
        send(32'h40200000, 1'b0, 2'd0, 16'h4100, 2'b00, "R1 half 2.5");
        send(32'h80000000, 1'b0, 2'd0, 16'h8000, 2'b00, "R4 neg zero");
        // R2 rounding
        send(32'h3F801000, 1'b0, 2'd0, 16'h3C00, 2'b01, "R2 tie even down");
        send(32'h3F803000, 1'b0, 2'd0, 16'h3C02, 2'b01, "R2 tie odd up");
        send(32'h3F803000, 1'b0, 2'd1, 16'h3C01, 2'b01, "R2 rtz");
        send(32'h3F800001, 1'b0, 2'd2, 16'h3C01, 2'b01, "R2 up pos");
        send(32'h3F800001, 1'b0, 2'd3, 16'h3C00, 2'b01, "R2 down pos");
        send(32'hBF800001, 1'b0, 2'd3, 16'hBC01, 2'b01, "R2 down neg");
        send(32'hBF800001, 1'b0, 2'd2, 16'hBC00, 2'b01, "R2 up neg");
        send(32'h3FFFFFFF, 1'b0, 2'd0, 16'h4000, 2'b01, "R2 carry half");
        send(32'h3FFFFFFF, 1'b1, 2'd0, 16'h4000, 2'b01, "R2 carry bf16");
        send(32'h3F808000, 1'b1, 2'd0, 16'h3F80, 2'b01, "R2 bf16 tie even");
        send(32'h3F818000, 1'b1, 2'd0, 16'h3F82, 2'b01, "R2 bf16 tie odd");
        // R3 overflow
        send(32'h477FE000, 1'b0, 2'd0, 16'h7BFF, 2'b00, "R9 half max exact");
        send(32'h477FF000, 1'b0, 2'd0, 16'h7C00, 2'b11, "R3 round into ovf");
        send(32'h47800000, 1'b0, 2'd0, 16'h7C00, 2'b11, "R3 rne ovf");
        send(32'h47800000, 1'b0, 2'd1, 16'h7BFF, 2'b11, "R3 rtz ovf");
        send(32'h47800000, 1'b0, 2'd2, 16'h7C00, 2'b11, "R3 up pos ovf");
        send(32'h47800000, 1'b0, 2'd3, 16'h7BFF, 2'b11, "R3 down pos ovf");
        send(32'hC7800000, 1'b0, 2'd2, 16'hFBFF, 2'b11, "R3 up neg ovf");
        send(32'hC7800000, 1'b0, 2'd3, 16'hFC00, 2'b11, "R3 down neg ovf");
        send(32'h7F7FFFFF, 1'b1, 2'd0, 16'h7F80, 2'b11, "R3 bf16 ovf");
        send(32'h7F7FFFFF, 1'b1, 2'd1, 16'h7F7F, 2'b01, "R3 bf16 rtz no ovf");
        // R4/R5 flushing
        send(32'h00000001, 1'b0, 2'd0, 16'h0000, 2'b01, "R4 denorm half");
        send(32'h80400000, 1'b1, 2'd0, 16'h8000, 2'b01, "R4 denorm bf16");
        send(32'h38000000, 1'b0, 2'd2, 16'h0000, 2'b01, "R5 underflow");
        send(32'hB8000000, 1'b0, 2'd0, 16'h8000, 2'b01, "R5 underflow neg");
        send(32'h38800000, 1'b0, 2'd0, 16'h0400, 2'b00, "R5 min normal");
        // R6/R7 NaN
        send(32'h7FC00001, 1'b0, 2'd0, 16'h7E00, 2'b00, "R6 qnan half");
        send(32'hFFE00000, 1'b0, 2'd0, 16'hFF00, 2'b00, "R6 qnan payload");
        send(32'hFFE00000, 1'b1, 2'd0, 16'hFFE0, 2'b00, "R6 qnan bf16");
        send(32'h7F800001, 1'b0, 2'd0, 16'h7E00, 2'b00, "R7 snan low");
        send(32'h7FA00000, 1'b0, 2'd0, 16'h7F00, 2'b00, "R7 snan half");
        send(32'h7FA00000, 1'b1, 2'd0, 16'h7FE0, 2'b00, "R7 snan bf16");
        // R8 infinity
        send(32'h7F800000, 1'b0, 2'd1, 16'h7C00, 2'b00, "R8 inf half");
        send(32'hFF800000, 1'b1, 2'd0, 16'hFF80, 2'b00, "R8 neg inf bf16");

        while (exp_q.size() != 0 || out_valid) @(posedge clk);
        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule